// File: doc/BRIEF.md
# Single-Lane 8b/10b Line Encoder

This block turns one byte and a control flag into one 10-bit transmission code group on every clock cycle, using the IEEE 802.3 Clause 36 code tables. It keeps the running disparity between characters. For each character it picks the code-group polarity that keeps the line DC-balanced, and it keeps runs of identical bits short. A link transmitter places it in front of a serializer. The transmitter feeds it one character per cycle and takes the registered code group one cycle later.

The control flag selects between the data mapping (Dx.y) and the special-character mapping (Kx.y). Only twelve byte values are legal as special characters. Any other value presented with the flag high is encoded as ordinary data, and an error output is raised for that character. A force strobe, together with a disparity value, replaces the stored running disparity for the character presented in the same cycle. This lets the transmitter start a sequence at a known polarity.

Top module: `enc_8b10b_lane`

## Requirements
- R1: Outputs are registered. A character presented at one rising edge appears on the outputs after that edge. While `rst_n` is low, `code_out` is 0, `disp_out` is 0 (negative) and `ctrl_bad` is 0.
- R2: When `is_ctrl` is low, the byte with bits HGF = y (data_in[7:5]) and EDCBA = x (data_in[4:0]) is encoded as Dx.y per Clause 36. Bit order is code_out[9:4] = a,b,c,d,e,i and code_out[3:0] = f,g,h,j, with a sent first.
- R3: When `is_ctrl` is high and the byte is one of 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD or 0xFE, the byte is encoded as the matching Kx.y code group.
- R4: When `is_ctrl` is high and the byte is outside that set, `code_out` carries the data code group for the byte and `ctrl_bad` is 1 for that character. Otherwise `ctrl_bad` is 0.
- R5: `disp_out` (0 = negative, 1 = positive) is the running disparity after the last emitted group. It changes only when that group has six ones (becomes positive) or four ones (becomes negative).
- R6: When `disp_force` is high, `disp_force_val` replaces the running disparity before the current character is encoded. The disparity that results from that character is then stored.
- R7: For Dx.7, the alternate 3b/4b form (0111 at negative, 1000 at positive) is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity. All other Dx.7 use 1110 / 0001.
- R8: Every emitted group has four, five or six ones. A group with six ones starts at negative disparity and a group with four ones starts at positive disparity.
- R9: Starting from negative disparity, 0xBC encodes as 0011101010 (flag low) and 0011111010 (flag high). 0x83, 0x78, 0x0F, 0x00, 0xBF and 0x3C (flag low) encode as 1100011101, 1100110011, 0101110100, 1001110100, 1010111010 and 0011101001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Byte to encode, HGFEDCBA |
| is_ctrl | input | 1 | 1 = encode as special character |
| disp_force | input | 1 | 1 = override running disparity this cycle |
| disp_force_val | input | 1 | Disparity used when forcing, 0 = negative |
| code_out | output | 10 | Registered code group, bit 9 sent first |
| disp_out | output | 1 | Running disparity after the last group |
| ctrl_bad | output | 1 | Control flag was set on an illegal byte |

## Verification
The properties assume that every input is a legal 8b/10b request, so that the disparity rules can be stated on output ones-counts alone. Any byte paired with any flag value is such a request. They also assume that a forced disparity value takes effect in the same cycle, so the polarity of the next group follows the forced value rather than `disp_out`. The stimulus holds inputs steady from one falling edge to the next and raises `disp_force` only on single, isolated characters. A property that depends on the stored disparity is therefore evaluated only when no force is present.

// File: rtl/enc_8b10b_lane.sv
`timescale 1ns/1ps
module enc_8b10b_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data_in,
  input  logic       is_ctrl,
  input  logic       disp_force,
  input  logic       disp_force_val,
  output logic [9:0] code_out,
  output logic       disp_out,
  output logic       ctrl_bad
);

  logic [4:0] x;
  logic [2:0] y;
  logic       rd_q, rd_in, rd_mid, rd_next;
  logic       k28, k7_ok, k_legal, use_k, alt7;
  logic [5:0] six_neg, six_out;
  logic [3:0] four_neg, four_out;
  logic       six_bal, four_bal, six_flip, four_flip;

  assign x       = data_in[4:0];
  assign y       = data_in[7:5];
  assign rd_in   = disp_force ? disp_force_val : rd_q;

  assign k28     = (x == 5'd28);
  assign k7_ok   = (y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30);
  assign k_legal = k28 | k7_ok;
  assign use_k   = is_ctrl & k_legal;

  always_comb begin
    case (x)
      5'd0:  six_neg = 6'b100111;
      5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;
      5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;
      5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;
      5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;
      5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;
      5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;
      5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;
      5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;
      5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;
      5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;
      5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;
      5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;
      5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;
      5'd27: six_neg = 6'b110110;
      5'd28: six_neg = (use_k && k28) ? 6'b001111 : 6'b001110;
      5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;
      default: six_neg = 6'b101011;
    endcase
  end

  assign six_bal  = ($countones(six_neg) == 3);
  assign six_flip = rd_in && (!six_bal || x == 5'd7);
  assign six_out  = six_flip ? ~six_neg : six_neg;
  assign rd_mid   = rd_in ^ !six_bal;

  assign alt7 = (y == 3'd7) &&
                ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                 ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));

  always_comb begin
    if (use_k) begin
      case (y)
        3'd0: four_neg = 4'b1011;
        3'd1: four_neg = 4'b0110;
        3'd2: four_neg = 4'b1010;
        3'd3: four_neg = 4'b1100;
        3'd4: four_neg = 4'b1101;
        3'd5: four_neg = 4'b0101;
        3'd6: four_neg = 4'b1001;
        default: four_neg = 4'b0111;
      endcase
    end else begin
      case (y)
        3'd0: four_neg = 4'b1011;
        3'd1: four_neg = 4'b1001;
        3'd2: four_neg = 4'b0101;
        3'd3: four_neg = 4'b1100;
        3'd4: four_neg = 4'b1101;
        3'd5: four_neg = 4'b1010;
        3'd6: four_neg = 4'b0110;
        default: four_neg = alt7 ? 4'b0111 : 4'b1110;
      endcase
    end
  end

  assign four_bal  = ($countones(four_neg) == 2);
  assign four_flip = rd_mid && (use_k || !four_bal || y == 3'd3);
  assign four_out  = four_flip ? ~four_neg : four_neg;
  assign rd_next   = rd_mid ^ !four_bal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      code_out <= '0;
      ctrl_bad <= 1'b0;
    end else begin
      rd_q     <= rd_next;
      code_out <= {six_out, four_out};
      ctrl_bad <= is_ctrl & !k_legal;
    end
  end

  assign disp_out = rd_q;

endmodule

module enc_8b10b_lane_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] data_in,
  input logic       is_ctrl,
  input logic       disp_force,
  input logic       disp_force_val,
  input logic [9:0] code_out,
  input logic       disp_out,
  input logic       ctrl_bad
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  assert_ones_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ($countones(code_out) >= 4 && $countones(code_out) <= 6));

  assert_heavy_ends_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $countones(code_out) == 6) |-> disp_out);

  assert_light_ends_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $countones(code_out) == 4) |-> !disp_out);

  assert_neg_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_force && !disp_out) |=> ($countones(code_out) >= 5));

  assert_pos_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_force && disp_out) |=> ($countones(code_out) <= 5));

  assert_force_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_force && !disp_force_val) |=> ($countones(code_out) >= 5));

  assert_force_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_force && disp_force_val) |=> ($countones(code_out) <= 5));

  assert_data_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctrl |=> !ctrl_bad);

  assert_illegal_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && data_in[4:0] != 5'd28 && data_in[7:5] != 3'd7) |=> ctrl_bad);

  assert_comma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && data_in == 8'hBC) |=>
      (!ctrl_bad && (code_out == 10'b0011111010 || code_out == 10'b1100000101)));
endmodule

bind enc_8b10b_lane enc_8b10b_lane_chk u_chk (.*);

// File: tb/enc_8b10b_lane_bench.sv
`timescale 1ns/1ps
module enc_8b10b_lane_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data_in = '0;
  logic       is_ctrl = 1'b0, disp_force = 1'b0, disp_force_val = 1'b0;
  logic [9:0] code_out;
  logic       disp_out, ctrl_bad;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  enc_8b10b_lane u_enc_8b10b_lane (.*);

  localparam logic [5:0] SIX [0:31] = '{
    6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
    6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
    6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
    6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
  localparam logic [3:0] DNEG [0:7] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                                        4'b1101, 4'b1010, 4'b0110, 4'b1110};
  localparam logic [3:0] KPOS [0:7] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                                        4'b0010, 4'b1010, 4'b0110, 4'b1000};
  localparam logic [7:0] KSET [0:11] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                         8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
  // {byte, ctrl, start disparity, expected error flag, expected code}
  localparam logic [20:0] VEC [0:13] = '{
    {8'hBC, 1'b0, 1'b0, 1'b0, 10'b0011101010},
    {8'hBC, 1'b1, 1'b0, 1'b0, 10'b0011111010},
    {8'h83, 1'b0, 1'b0, 1'b0, 10'b1100011101},
    {8'h78, 1'b0, 1'b0, 1'b0, 10'b1100110011},
    {8'h0F, 1'b0, 1'b0, 1'b0, 10'b0101110100},
    {8'h00, 1'b0, 1'b0, 1'b0, 10'b1001110100},
    {8'hBF, 1'b0, 1'b0, 1'b0, 10'b1010111010},
    {8'h3C, 1'b0, 1'b0, 1'b0, 10'b0011101001},
    {8'hBC, 1'b1, 1'b1, 1'b0, 10'b1100000101},
    {8'hF7, 1'b1, 1'b0, 1'b0, 10'b1110101000},
    {8'hFE, 1'b1, 1'b1, 1'b0, 10'b1000010111},
    {8'h00, 1'b1, 1'b0, 1'b1, 10'b1001110100},
    {8'h3C, 1'b1, 1'b0, 1'b0, 10'b0011111001},
    {8'h45, 1'b1, 1'b1, 1'b1, 10'b1010010101}};

  function automatic logic [10:0] model(input logic [7:0] d, input logic k, input logic rd);
    logic [4:0] x; logic [2:0] y; logic kk, rd1, rd2; logic [5:0] c; logic [3:0] f;
    x = d[4:0]; y = d[7:5];
    kk = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
    c = (kk && x == 28) ? 6'b001111 : SIX[x];
    if (rd) begin
      if (x == 7) c = 6'b000111;
      else if ($countones(c) > 3) c = ~c;
    end
    rd1 = ($countones(c) == 3) ? rd : ($countones(c) > 3);
    if (kk) f = rd1 ? KPOS[y] : ~KPOS[y];
    else if (y == 7 && ((!rd1 && (x == 17 || x == 18 || x == 20)) ||
                        ( rd1 && (x == 11 || x == 13 || x == 14)))) f = rd1 ? 4'b1000 : 4'b0111;
    else begin
      f = DNEG[y];
      if (rd1 && (y == 3 || $countones(f) != 2)) f = ~f;
    end
    rd2 = ($countones(f) == 2) ? rd1 : ($countones(f) > 2);
    return {rd2, c, f};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic k, input logic f, input logic v);
    data_in = d; is_ctrl = k; disp_force = f; disp_force_val = v;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [10:0] m;
    logic rd;
    repeat (3) @(negedge clk);
    chk("R1 reset code", code_out, 0);
    chk("R1 reset disparity", disp_out, 0);
    chk("R1 reset flag", ctrl_bad, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      apply(VEC[i][20:13], VEC[i][12], 1'b1, VEC[i][11]);
      chk("R9 vector code", code_out, VEC[i][9:0]);
      chk("R4 vector flag", ctrl_bad, VEC[i][10]);
      chk("R5 vector disparity", disp_out, ($countones(VEC[i][9:0]) == 5) ? VEC[i][11] :
                                            ($countones(VEC[i][9:0]) > 5));
    end

    apply(8'hF1, 0, 1, 0); chk("R7 D17.7 neg", code_out, 10'b1000110111);
    apply(8'hF4, 0, 1, 1); chk("R7 D20.7 pos", code_out, 10'b0010110001);
    apply(8'hEE, 0, 1, 1); chk("R7 D14.7 pos", code_out, 10'b0111001000);
    apply(8'hEE, 0, 1, 0); chk("R7 D14.7 neg", code_out, 10'b0111001110);
    apply(8'hEB, 0, 1, 0); chk("R7 D11.7 neg", code_out, 10'b1101001110);

    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 256; v++) begin
        m = model(8'(v), 1'b0, 1'(r));
        apply(8'(v), 1'b0, 1'b1, 1'(r));
        chk("R2 data code", code_out, m[9:0]);
        chk("R6 forced disparity result", disp_out, m[10]);
      end
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 12; i++) begin
        m = model(KSET[i], 1'b1, 1'(r));
        apply(KSET[i], 1'b1, 1'b1, 1'(r));
        chk("R3 control code", code_out, m[9:0]);
        chk("R3 control flag", ctrl_bad, 0);
      end

    apply(8'h00, 0, 1, 0);
    rd = disp_out;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d; logic k, f, v;
      d = 8'($urandom);
      k = ($urandom % 4) == 0;
      if (k && ($urandom % 2)) d = KSET[$urandom % 12];
      f = ($urandom % 16) == 0;
      v = 1'($urandom);
      m = model(d, k, f ? v : rd);
      apply(d, k, f, v);
      chk("R5 stream code", code_out, m[9:0]);
      chk("R5 stream disparity", disp_out, m[10]);
      chk("R4 stream flag", ctrl_bad, k && !(d[4:0] == 28 || (d[7:5] == 7 &&
          (d[4:0] == 23 || d[4:0] == 27 || d[4:0] == 29 || d[4:0] == 30))));
      chk("R8 ones count", ($countones(code_out) >= 4 && $countones(code_out) <= 6), 1);
      rd = m[10];
    end

    apply(8'h00, 0, 1, 0);
    chk("R1 latency one cycle", code_out, 10'b1001110100);
    apply(8'h00, 0, 1, 1);
    chk("R6 force positive", code_out, 10'b0110001011);
    rst_n = 1'b0;
    apply(8'h00, 0, 1, 1);
    chk("R1 reset mid-stream disparity", disp_out, 0);
    chk("R1 reset mid-stream code", code_out, 0);
    rst_n = 1'b1;
    apply(8'h00, 0, 0, 1);
    chk("R1 after reset starts negative", code_out, 10'b1001110100);

    done = 1;
    summary();
  end
endmodule